// File: doc/BRIEF.md
# Wake-up event status and power-management event control

This block gathers three network wake-up indications (a received wake-up frame, a received magic packet and a detected change of link state) and keeps a sticky status bit for each of them. Each indication arrives as a single-cycle pulse from logic outside the block. Software sees the three status bits and two wake enables in one 32-bit register. It clears a status bit by writing a one to it and sets or clears the enables by plain writes.

A sticky power-management event flag is raised when an enabled indication arrives. Magic-packet and link-change indications are gated by the register enables. Wake-up frames are gated by a separate enable input. The status bits and the event flag keep their values through the ordinary hardware/software reset. Only the power-up reset, or an explicit clear, removes them. The ordinary reset does restore the two enables, to a default taken from two configuration inputs.

Top module: `wake_evt_ctrl`

## Requirements
- R1: A pulse on `evt_link`, `evt_magic` or `evt_frame` sets register bit 0, bit 1 or bit 2 respectively. The bit reads 1 from the next clock edge and stays 1.
- R2: A register write with a 1 in bit 0, 1 or 2 clears that status bit at that clock edge. A 0 in those positions leaves the bit unchanged.
- R3: When an event pulse and a write-one-to-clear reach the same status bit in the same cycle, the bit is set.
- R4: A low `rst_n` changes neither the status bits nor `pme_status`. A low `por_n` clears all status bits and `pme_status`.
- R5: Register bit 8 is the link-change wake enable and bit 9 is the magic-packet wake enable. Both are read/write, and a write takes effect at the clock edge.
- R6: While `por_n` or `rst_n` is low, both enables load 1 if `cfg_pm_en` and `cfg_wol_en` are both high, and load 0 otherwise.
- R7: An `evt_link` or `evt_magic` pulse sets `pme_status` at the next edge when its enable bit is 1. It leaves `pme_status` unchanged when that enable bit is 0.
- R8: An `evt_frame` pulse sets `pme_status` only when `frame_wake_en` is high in the same cycle.
- R9: `pme_status` stays set until a `pme_clr` pulse clears it. If `pme_clr` and an enabled event arrive in the same cycle, the flag stays set.
- R10: All register bits other than 0, 1, 2, 8 and 9 read 0, whatever has been written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, synchronous, active low |
| rst_n | input | 1 | Hardware/software reset, synchronous, active low |
| cfg_pm_en | input | 1 | Power-management configuration bit, used for the enable default |
| cfg_wol_en | input | 1 | Wake-on-LAN configuration bit, used for the enable default |
| frame_wake_en | input | 1 | Allows wake-up frames to raise the event flag |
| evt_link | input | 1 | Link state change pulse |
| evt_magic | input | 1 | Magic packet received pulse |
| evt_frame | input | 1 | Wake-up frame received pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| pme_clr | input | 1 | Clears the power-management event flag |
| pme_status | output | 1 | Sticky power-management event flag |

## Verification
The hardest state to reach is a status bit that is hit by its event pulse and by a write-one-to-clear in the same cycle. A close second is a set status bit and a raised flag that must live through an ordinary reset while the enables change around them. The stimulus first sets all three status bits and the flag. It then pulses `rst_n` with different configuration inputs and checks that only the enable field moves. Separate scenarios drive an event and its clear on the same edge, for the register bits and for `pme_clr` alike.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned NUM_EVT    = 3;
    localparam int unsigned STAT_LINK  = 0;
    localparam int unsigned STAT_MAGIC = 1;
    localparam int unsigned STAT_FRAME = 2;
    localparam int unsigned EN_LINK    = 8;
    localparam int unsigned EN_MAGIC   = 9;

    typedef struct packed {
        logic magic;
        logic link;
    } wake_en_t;
endpackage

// File: rtl/wake_sticky_bit.sv
module wake_sticky_bit (
    input  logic clk,
    input  logic por_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d, q_q;

    // set has priority over clear; power-up reset over both
    always_comb begin
        q_d = q_q;
        if (clr_i) q_d = 1'b0;
        if (set_i) q_d = 1'b1;
        if (!por_n) q_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/wake_enable_reg.sv
module wake_enable_reg
    import wake_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     rst_n,
    input  logic     cfg_pm_en,
    input  logic     cfg_wol_en,
    input  logic     wr_i,
    input  logic     wr_link_i,
    input  logic     wr_magic_i,
    output wake_en_t en_o
);
    wake_en_t en_d, en_q;
    logic     dflt;

    assign dflt = cfg_pm_en & cfg_wol_en;

    always_comb begin
        en_d = en_q;
        if (wr_i) begin
            en_d.link  = wr_link_i;
            en_d.magic = wr_magic_i;
        end
        if (!por_n || !rst_n) begin
            en_d.link  = dflt;
            en_d.magic = dflt;
        end
    end

    always_ff @(posedge clk) begin
        en_q <= en_d;
    end

    assign en_o = en_q;
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
    import wake_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             cfg_pm_en,
    input  logic             cfg_wol_en,
    input  logic             frame_wake_en,
    input  logic             evt_link,
    input  logic             evt_magic,
    input  logic             evt_frame,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             pme_clr,
    output logic             pme_status
);
    logic [NUM_EVT-1:0] evt_vec;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] stat_q;
    wake_en_t           en_q;
    logic               pme_set;
    logic               unused_wdata;

    assign evt_vec[STAT_LINK]  = evt_link;
    assign evt_vec[STAT_MAGIC] = evt_magic;
    assign evt_vec[STAT_FRAME] = evt_frame;
    assign clr_vec = reg_wr ? reg_wdata[NUM_EVT-1:0] : '0;
    assign unused_wdata = ^{reg_wdata[REG_W-1:EN_MAGIC+1], reg_wdata[EN_LINK-1:NUM_EVT]};

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_stat
        wake_sticky_bit u_stat (
            .clk   (clk),
            .por_n (por_n),
            .set_i (evt_vec[i]),
            .clr_i (clr_vec[i]),
            .q_o   (stat_q[i])
        );
    end

    wake_enable_reg u_en (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .cfg_pm_en  (cfg_pm_en),
        .cfg_wol_en (cfg_wol_en),
        .wr_i       (reg_wr),
        .wr_link_i  (reg_wdata[EN_LINK]),
        .wr_magic_i (reg_wdata[EN_MAGIC]),
        .en_o       (en_q)
    );

    assign pme_set = (evt_link & en_q.link) | (evt_magic & en_q.magic)
                   | (evt_frame & frame_wake_en);

    wake_sticky_bit u_pme (
        .clk   (clk),
        .por_n (por_n),
        .set_i (pme_set),
        .clr_i (pme_clr),
        .q_o   (pme_status)
    );

    always_comb begin
        reg_rdata                = '0;
        reg_rdata[NUM_EVT-1:0]   = stat_q;
        reg_rdata[EN_LINK]       = en_q.link;
        reg_rdata[EN_MAGIC]      = en_q.magic;
    end
endmodule

// File: rtl/wake_evt_ctrl_chk.sv
module wake_evt_ctrl_chk
    import wake_pkg::*;
(
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input logic             cfg_pm_en,
    input logic             cfg_wol_en,
    input logic             frame_wake_en,
    input logic             evt_link,
    input logic             evt_magic,
    input logic             evt_frame,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             pme_clr,
    input logic             pme_status
);
    localparam logic [REG_W-1:0] USED_MASK =
        (REG_W'(1) << EN_LINK) | (REG_W'(1) << EN_MAGIC) | ((REG_W'(1) << NUM_EVT) - REG_W'(1));

    AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (!por_n)
        evt_link |=> reg_rdata[STAT_LINK]);                                         // R1
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (reg_wr && reg_wdata[STAT_MAGIC] && !evt_magic) |=> !reg_rdata[STAT_MAGIC]); // R2
    AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        (evt_frame && reg_wr && reg_wdata[STAT_FRAME]) |=> reg_rdata[STAT_FRAME]);  // R3
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        (reg_rdata[STAT_LINK] && !(reg_wr && reg_wdata[STAT_LINK])) |=> reg_rdata[STAT_LINK]); // R4
    AST_EN_DEFAULT: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (reg_rdata[EN_MAGIC:EN_LINK] == {2{$past(cfg_pm_en && cfg_wol_en)}})); // R6
    AST_PME_ON_ENABLED: assert property (@(posedge clk) disable iff (!por_n)
        (evt_magic && reg_rdata[EN_MAGIC]) |=> pme_status);                         // R7
    AST_PME_NO_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        (!pme_status && !(evt_link && reg_rdata[EN_LINK]) && !(evt_magic && reg_rdata[EN_MAGIC])
         && !(evt_frame && frame_wake_en)) |=> !pme_status);                        // R8
    AST_PME_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (pme_status && !pme_clr) |=> pme_status);                                   // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |-> ((reg_rdata & ~USED_MASK) == '0));                                 // R10
endmodule

bind wake_evt_ctrl wake_evt_ctrl_chk u_chk (.*);

// File: tb/tb_wake_evt_ctrl.sv
module tb_wake_evt_ctrl;
    logic        clk = 1'b0;
    logic        por_n, rst_n, cfg_pm_en, cfg_wol_en, frame_wake_en;
    logic        evt_link, evt_magic, evt_frame, reg_wr, pme_clr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        pme_status;
    int          n_checks = 0;
    int          n_errors = 0;

    always #2 clk = ~clk;

    wake_evt_ctrl dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_pm_en(cfg_pm_en),
        .cfg_wol_en(cfg_wol_en), .frame_wake_en(frame_wake_en),
        .evt_link(evt_link), .evt_magic(evt_magic), .evt_frame(evt_frame),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pme_clr(pme_clr), .pme_status(pme_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // advance one edge, settle away from it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write(input logic [31:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_por(input logic pm, input logic wol);
        cfg_pm_en = pm; cfg_wol_en = wol; por_n = 1'b0;
        step(); step();
        por_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_por(1'b1, 1'b1);
        check("R6 default both cfg set", reg_rdata, 32'h300);
        check("R4 pme after power-up", {31'd0, pme_status}, 32'd0);
        do_por(1'b1, 1'b0);
        check("R6 default one cfg clear", reg_rdata, 32'h000);
    endtask

    task automatic t_events();
        evt_link = 1'b1; step(); evt_link = 1'b0;
        check("R1 link status", reg_rdata, 32'h001);
        check("R7 disabled link no pme", {31'd0, pme_status}, 32'd0);
        evt_magic = 1'b1; step(); evt_magic = 1'b0;
        check("R1 magic status", reg_rdata, 32'h003);
        evt_frame = 1'b1; step(); evt_frame = 1'b0;
        check("R1 frame status", reg_rdata, 32'h007);
        check("R8 frame without enable no pme", {31'd0, pme_status}, 32'd0);
        step(); step();
        check("R1 status stays", reg_rdata, 32'h007);
    endtask

    task automatic t_w1c();
        write(32'h002);
        check("R2 clear magic only", reg_rdata, 32'h005);
        write(32'h000);
        check("R2 zero write no effect", reg_rdata, 32'h005);
        write(32'h005);
        check("R2 clear remaining", reg_rdata, 32'h000);
    endtask

    task automatic t_collision();
        evt_magic = 1'b1;
        write(32'h002);
        evt_magic = 1'b0;
        check("R3 event beats clear", reg_rdata, 32'h002);
        write(32'h002);
        check("R2 clear after collision", reg_rdata, 32'h000);
    endtask

    task automatic t_pme();
        write(32'h100);
        check("R5 link enable written", reg_rdata, 32'h100);
        evt_magic = 1'b1; step(); evt_magic = 1'b0;
        check("R7 magic disabled no pme", {31'd0, pme_status}, 32'd0);
        evt_link = 1'b1; step(); evt_link = 1'b0;
        check("R7 enabled link sets pme", {31'd0, pme_status}, 32'd1);
        step();
        check("R9 pme sticky", {31'd0, pme_status}, 32'd1);
        pme_clr = 1'b1; step(); pme_clr = 1'b0;
        check("R9 pme clear", {31'd0, pme_status}, 32'd0);
        pme_clr = 1'b1; evt_link = 1'b1; step(); pme_clr = 1'b0; evt_link = 1'b0;
        check("R9 event beats pme clear", {31'd0, pme_status}, 32'd1);
        pme_clr = 1'b1; step(); pme_clr = 1'b0;
        write(32'h200);
        check("R5 magic enable written", reg_rdata, 32'h203);
        evt_magic = 1'b1; step(); evt_magic = 1'b0;
        check("R7 enabled magic sets pme", {31'd0, pme_status}, 32'd1);
        pme_clr = 1'b1; step(); pme_clr = 1'b0;
        frame_wake_en = 1'b1; evt_frame = 1'b1; step(); evt_frame = 1'b0; frame_wake_en = 1'b0;
        check("R8 frame with enable sets pme", {31'd0, pme_status}, 32'd1);
        check("R1 all status set", reg_rdata, 32'h207);
    endtask

    task automatic t_hw_reset();
        cfg_pm_en = 1'b1; cfg_wol_en = 1'b1;
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check("R4 R6 hw reset keeps status, loads enables", reg_rdata, 32'h307);
        check("R4 hw reset keeps pme", {31'd0, pme_status}, 32'd1);
        cfg_wol_en = 1'b0;
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check("R6 hw reset enable default zero", reg_rdata, 32'h007);
    endtask

    task automatic t_por_clear();
        do_por(1'b0, 1'b0);
        check("R4 power-up clears status", reg_rdata, 32'h000);
        check("R4 power-up clears pme", {31'd0, pme_status}, 32'd0);
    endtask

    task automatic t_reserved();
        write(32'hFFFF_FFFF);
        check("R10 reserved bits read zero", reg_rdata, 32'h300);
    endtask

    initial begin
        #(200000 * 4);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b1; cfg_pm_en = 1'b0; cfg_wol_en = 1'b0;
        frame_wake_en = 1'b0; evt_link = 1'b0; evt_magic = 1'b0; evt_frame = 1'b0;
        reg_wr = 1'b0; reg_wdata = '0; pme_clr = 1'b0;
        #1;
        t_reset_state();
        t_events();
        t_w1c();
        t_collision();
        t_pme();
        t_hw_reset();
        t_por_clear();
        t_reserved();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule